// File: doc/BRIEF.md
# Sequential Floating-Point Adder

This block adds two floating-point words in a simple format and works one step per clock. Each word holds a sign bit at the top, an unsigned exponent field below it, and a mantissa field in the low bits. The mantissa's leading 1 is stored explicitly in its top bit. Encodings are limited to normalized words (mantissa top bit 1) and the all-zero word. NaN, infinity, denormals and IEEE rounding are not supported.

A one-cycle `start` pulse captures both operands. The next cycle compares the exponents and picks one of five cases:

- The exponents are equal.
- X has the larger exponent and the gap is narrow.
- X has the larger exponent and the gap is wide.
- Y has the larger exponent and the gap is narrow.
- Y has the larger exponent and the gap is wide.

A wide gap returns the operand with the larger exponent unchanged. A narrow gap shifts the smaller mantissa right to line it up, and the two magnitudes are then added or subtracted. Normalization then moves the sum one bit per cycle, adjusting the exponent each time, until the sum is normalized, is zero, or hits an exponent limit. `done` pulses for one cycle when `result` and `overflow` are updated.

Top module: `fpadd_seq`

## Requirements
- R1: While reset is held and after it is released, `result` is all zeros and `done` and `overflow` are low.
- R2: Operands with equal exponents have their mantissas combined, and the common exponent is kept before normalization.
- R3: When the X exponent exceeds the Y exponent by less than MAN_W, the Y mantissa is shifted right by the gap before the add. Bits shifted out are dropped.
- R4: When the X exponent exceeds the Y exponent by MAN_W or more, `result` equals `x` bit for bit and `overflow` is low.
- R5: The mirror cases of R3 and R4 apply when the Y exponent is larger: the X mantissa is aligned, or `y` is returned unchanged.
- R6: Operands with different signs subtract the smaller magnitude from the larger. The result takes the sign of the larger magnitude, and on equal exponents the larger mantissa counts as the larger magnitude.
- R7: A carry out of the mantissa sum shifts the sum right by one and raises the exponent by one.
- R8: A sum whose top mantissa bit is 0 is shifted left one bit per cycle, lowering the exponent each time, until that bit is 1. Every nonzero result has mantissa bit MAN_W-1 set.
- R9: A zero mantissa sum produces the all-zero word.
- R10: A carry out at the all-ones exponent keeps the exponent at all ones, keeps the sum shifted right by one as the mantissa, and raises `overflow`. Any result without this condition has `overflow` low.
- R11: A left shift needed while the exponent is already zero produces the all-zero word.
- R12: `done` is high for exactly one cycle per operation. `result` and `overflow` hold between completions. A `start` arriving while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that captures `x` and `y` and begins an addition |
| x | input | 1+EXP_W+MAN_W | First operand {sign, exponent, mantissa} |
| y | input | 1+EXP_W+MAN_W | Second operand {sign, exponent, mantissa} |
| result | output | 1+EXP_W+MAN_W | Sum in the same format, held until the next completion |
| overflow | output | 1 | Exponent saturated during the last completed addition |
| done | output | 1 | One-cycle pulse marking a new `result` |

## Verification
The right shift after a carry-out and the exponent saturation can happen in the same normalization step. This occurs when two operands at the all-ones exponent produce a carry. A directed case builds that sum, and the check requires three things together: an exponent of all ones, the halved sum as the mantissa, and the flag set. The operation that follows must clear the flag.

Arrival of a new `start` can also overlap an operation in progress. A second operand pair is pulsed mid-operation, and the result must still match the first pair.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM
  } fpaState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // capture operands
    logic align;     // compare exponents, align or bypass
    logic addSub;    // combine magnitudes
    logic normStep;  // one normalization cycle
  } fpaStrobe_t;

endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       bypass,
  input  logic       normFin,
  output fpaStrobe_t stb,
  output logic       done,
  output logic       busy
);

  fpaState_e state, stateNxt;
  logic      finishNow;

  always_comb begin
    stateNxt  = state;
    stb       = '0;
    finishNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateNxt = ST_ALIGN;
        end
      end
      ST_ALIGN: begin
        stb.align = 1'b1;
        if (bypass) begin
          finishNow = 1'b1;
          stateNxt  = ST_IDLE;
        end else begin
          stateNxt  = ST_ADD;
        end
      end
      ST_ADD: begin
        stb.addSub = 1'b1;
        stateNxt   = ST_NORM;
      end
      ST_NORM: begin
        stb.normStep = 1'b1;
        if (normFin) begin
          finishNow = 1'b1;
          stateNxt  = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= finishNow;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fpaStrobe_t               stb,
  input  logic [EXP_W+MAN_W:0]     x,
  input  logic [EXP_W+MAN_W:0]     y,
  output logic                     bypass,
  output logic                     normFin,
  output logic [EXP_W+MAN_W:0]     result,
  output logic                     overflow
);

  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic [W-1:0]     xR, yR;
  logic             sx, sy;
  logic [EXP_W-1:0] ex, ey;
  logic [MAN_W-1:0] mx, my;

  // Operand capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR <= '0;
      yR <= '0;
    end else if (stb.load) begin
      xR <= x;
      yR <= y;
    end
  end

  assign sx = xR[W-1];
  assign sy = yR[W-1];
  assign ex = xR[W-2:MAN_W];
  assign ey = yR[W-2:MAN_W];
  assign mx = xR[MAN_W-1:0];
  assign my = yR[MAN_W-1:0];

  // Exponent comparison and alignment
  logic             xBig;
  logic [EXP_W-1:0] bigExp, smallExp, expGap;
  logic [MAN_W-1:0] bigMan, smallMan, shiftedSmall;
  logic             bigSgn;
  logic [W-1:0]     bigWord;

  always_comb begin
    xBig     = (ex > ey) || ((ex == ey) && (mx >= my));
    bigExp   = xBig ? ex : ey;
    smallExp = xBig ? ey : ex;
    bigMan   = xBig ? mx : my;
    smallMan = xBig ? my : mx;
    bigSgn   = xBig ? sx : sy;
    bigWord  = xBig ? xR : yR;
    expGap   = bigExp - smallExp;
    bypass   = (32'(expGap) >= MAN_W);
    shiftedSmall = smallMan >> expGap;
  end

  // Aligned operands, working sum and exponent
  logic [MAN_W-1:0] bigManR, smallManR;
  logic             subR, sgnR;
  logic [EXP_W-1:0] expR;
  logic [MAN_W:0]   sumR;

  // Normalization status
  logic sumZero, carry, lead, expTop, expBot, underflow;
  logic [W-1:0] finalWord;
  logic         finalOvf;

  always_comb begin
    sumZero   = (sumR == '0);
    carry     = sumR[MAN_W];
    lead      = sumR[MAN_W-1];
    expTop    = (expR == EXP_MAX);
    expBot    = (expR == '0);
    underflow = !carry && !lead && expBot;
    normFin   = sumZero || (carry && expTop) || (!carry && lead) || underflow;
    if (sumZero || underflow) begin
      finalWord = '0;
    end else if (carry) begin
      finalWord = {sgnR, EXP_MAX, sumR[MAN_W:1]};
    end else begin
      finalWord = {sgnR, expR, sumR[MAN_W-1:0]};
    end
    finalOvf = carry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bigManR   <= '0;
      smallManR <= '0;
      subR      <= 1'b0;
      sgnR      <= 1'b0;
      expR      <= '0;
      sumR      <= '0;
    end else begin
      if (stb.align) begin
        bigManR   <= bigMan;
        smallManR <= shiftedSmall;
        subR      <= sx ^ sy;
        sgnR      <= bigSgn;
        expR      <= bigExp;
      end
      if (stb.addSub) begin
        sumR <= subR ? ({1'b0, bigManR} - {1'b0, smallManR})
                     : ({1'b0, bigManR} + {1'b0, smallManR});
      end
      if (stb.normStep && !normFin) begin
        if (carry) begin
          sumR <= sumR >> 1;
          expR <= expR + 1'b1;
        end else begin
          sumR <= sumR << 1;
          expR <= expR - 1'b1;
        end
      end
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      overflow <= 1'b0;
    end else if (stb.align && bypass) begin
      result   <= bigWord;
      overflow <= 1'b0;
    end else if (stb.normStep && normFin) begin
      result   <= finalWord;
      overflow <= finalOvf;
    end
  end

endmodule

// File: rtl/fpadd_seq.sv
module fpadd_seq
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [EXP_W+MAN_W:0] x,
  input  logic [EXP_W+MAN_W:0] y,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 overflow,
  output logic                 done
);

  fpaStrobe_t stb;
  logic       bypass;
  logic       normFin;
  logic       busy;

  fpadd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .bypass  (bypass),
    .normFin (normFin),
    .stb     (stb),
    .done    (done),
    .busy    (busy)
  );

  fpadd_dp #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .x        (x),
    .y        (y),
    .bypass   (bypass),
    .normFin  (normFin),
    .result   (result),
    .overflow (overflow)
  );

endmodule

// File: rtl/fpadd_seq_chk.sv
module fpadd_seq_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 overflow,
  input logic [EXP_W+MAN_W:0] result
);

  localparam int W = 1 + EXP_W + MAN_W;

  // R12: completion pulse lasts one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: outputs only change with a completion
  a_r12_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  a_r12_ovf_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(overflow));

  // R12: start while busy does not restart the sequence
  a_r12_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  // R10: saturated result carries the all-ones exponent
  a_r10_sat_exp: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (result[W-2:MAN_W] == {EXP_W{1'b1}}));

  // R9: zero mantissa only appears in the all-zero word
  a_r9_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    (done && (result[MAN_W-1:0] == '0)) |-> (result == '0));

  // R8: nonzero results are normalized
  a_r8_normalized: assert property (@(posedge clk) disable iff (!rstN)
    (done && (result != '0)) |-> result[MAN_W-1]);

endmodule

bind fpadd_seq fpadd_seq_chk #(
  .EXP_W (EXP_W),
  .MAN_W (MAN_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .overflow (overflow),
  .result   (result)
);

// File: tb/fpadd_seq_tb.sv
`timescale 1ns/1ps
module fpadd_seq_tb;

  localparam int EXP_W = 8;
  localparam int MAN_W = 16;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic [W-1:0] result;
  logic         overflow;
  logic         done;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fpadd_seq #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .x        (x),
    .y        (y),
    .result   (result),
    .overflow (overflow),
    .done     (done)
  );

  function automatic logic [W-1:0] mk(bit s, int e, int m);
    logic [EXP_W-1:0] eL = e[EXP_W-1:0];
    logic [MAN_W-1:0] mL = m[MAN_W-1:0];
    return {s, eL, mL};
  endfunction

  // Reference model: returns {overflow, word}
  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b);
    int ea = int'(a[W-2:MAN_W]);
    int eb = int'(b[W-2:MAN_W]);
    int ma = int'(a[MAN_W-1:0]);
    int mb = int'(b[MAN_W-1:0]);
    bit sa = a[W-1];
    bit sb = b[W-1];
    bit aBig = (ea > eb) || (ea == eb && ma >= mb);
    int e  = aBig ? ea : eb;
    int d  = aBig ? ea - eb : eb - ea;
    int bm = aBig ? ma : mb;
    int sm = aBig ? mb : ma;
    bit sg = aBig ? sa : sb;
    int s;
    if (d >= MAN_W) return {1'b0, (aBig ? a : b)};
    sm = sm >> d;
    s  = (sa != sb) ? bm - sm : bm + sm;
    for (int k = 0; k < 4 * MAN_W; k++) begin
      if (s == 0) return '0;
      if (s >= (1 << MAN_W)) begin
        if (e == EMAX) return {1'b1, mk(sg, EMAX, s >> 1)};
        s = s >> 1;
        e = e + 1;
      end else if ((s >> (MAN_W - 1)) & 1) begin
        return {1'b0, mk(sg, e, s)};
      end else begin
        if (e == 0) return '0;
        s = s << 1;
        e = e - 1;
      end
    end
    return '0;
  endfunction

  task automatic check(bit ok, string req, logic [W:0] act, logic [W:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Launch one addition and wait for completion
  task automatic launch(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    x = a;
    y = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(string req, output bit seen);
    int cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    seen = done;
    if (!seen) check(1'b0, {req, " no done"}, '0, 1);
  endtask

  task automatic runOp(logic [W-1:0] a, logic [W-1:0] b, string req);
    logic [W:0] exp = model(a, b);
    bit seen;
    launch(a, b);
    waitDone(req, seen);
    if (seen) begin
      check({overflow, result} == exp, req, {overflow, result}, exp);
      @(negedge clk);
      check(!done, "R12 done pulse", {W'(0), done}, '0);
    end
  endtask

  function automatic logic [W-1:0] randOp(int baseExp);
    int e;
    if ($urandom_range(0, 15) == 0) return '0;
    e = baseExp;
    if (e < 0) e = 0;
    if (e > EMAX) e = EMAX;
    return mk(1'($urandom_range(0, 1)), e, 32'h8000 | ($urandom & 32'h7fff));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    bit seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result == '0 && !done && !overflow, "R1 reset", {overflow, result}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(result == '0 && !done && !overflow, "R1 after release", {overflow, result}, '0);

    // R2 with R7: equal exponents, carry out
    runOp(mk(0, 10, 'h8000), mk(0, 10, 'h8000), "R2 R7 equal exp carry");
    check(result == mk(0, 11, 'h8000), "R7 exp increment", {1'b0, result}, {1'b0, mk(0, 11, 'h8000)});
    // R3: narrow gap, X larger
    runOp(mk(0, 20, 'hC000), mk(0, 5, 'h8000), "R3 align y");
    check(result == mk(0, 20, 'hC001), "R3 shifted value", {1'b0, result}, {1'b0, mk(0, 20, 'hC001)});
    // R4: wide gap exactly MAN_W
    runOp(mk(1, 21, 'hC000), mk(0, 5, 'hFFFF), "R4 bypass x");
    check(result == mk(1, 21, 'hC000), "R4 x unchanged", {1'b0, result}, {1'b0, mk(1, 21, 'hC000)});
    // R5: mirror cases
    runOp(mk(0, 5, 'h8000), mk(1, 30, 'hA5A5), "R5 bypass y");
    check(result == mk(1, 30, 'hA5A5), "R5 y unchanged", {1'b0, result}, {1'b0, mk(1, 30, 'hA5A5)});
    runOp(mk(0, 3, 'h8000), mk(0, 4, 'h8000), "R5 align x");
    check(result == mk(0, 4, 'hC000), "R5 aligned sum", {1'b0, result}, {1'b0, mk(0, 4, 'hC000)});
    // R6 and R8: sign mismatch, larger mantissa wins
    runOp(mk(0, 7, 'h8000), mk(1, 7, 'hC000), "R6 R8 subtract");
    check(result == mk(1, 6, 'h8000), "R6 sign of larger", {1'b0, result}, {1'b0, mk(1, 6, 'h8000)});
    // R9: exact cancellation
    runOp(mk(0, 9, 'h9000), mk(1, 9, 'h9000), "R9 zero");
    check(result == '0, "R9 all zero", {1'b0, result}, '0);
    // R8: long left normalization
    runOp(mk(0, 40, 'h8001), mk(1, 40, 'h8000), "R8 deep shift");
    check(result == mk(0, 25, 'h8000), "R8 exp decrement", {1'b0, result}, {1'b0, mk(0, 25, 'h8000)});
    // R10: saturation with carry at max exponent
    runOp(mk(0, EMAX, 'h8000), mk(0, EMAX, 'hC000), "R10 saturate");
    check(overflow && result == mk(0, EMAX, 'hA000), "R10 flag and value",
          {overflow, result}, {1'b1, mk(0, EMAX, 'hA000)});
    runOp(mk(0, 12, 'h8000), mk(0, 12, 'h8000), "R10 flag cleared");
    check(!overflow, "R10 no overflow", {W'(0), overflow}, '0);
    // R11: exponent underflow
    runOp(mk(0, 2, 'h8001), mk(1, 2, 'h8000), "R11 underflow");
    check(result == '0, "R11 zero word", {1'b0, result}, '0);

    // R12: start while busy is ignored
    launch(mk(0, 20, 'hC000), mk(0, 5, 'h8000));
    x = mk(1, 21, 'hC000);
    y = mk(0, 5, 'hFFFF);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R12 busy", seen);
    check(result == mk(0, 20, 'hC001), "R12 busy start ignored",
          {1'b0, result}, {1'b0, mk(0, 20, 'hC001)});
    // R12: result holds after completion
    held = result;
    repeat (6) @(negedge clk);
    check(result == held && !done, "R12 hold", {done, result}, {1'b0, held});

    // Random mix of exponent relations (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 300; i++) begin
      int ea = int'($urandom_range(0, EMAX));
      int sel = int'($urandom_range(0, 3));
      int eb;
      case (sel)
        0: eb = ea;
        1: eb = ea + int'($urandom_range(0, MAN_W - 1)) - MAN_W / 2;
        2: eb = ea + ((ea > EMAX / 2) ? -1 : 1) * int'($urandom_range(MAN_W - 1, MAN_W + 4));
        default: eb = int'($urandom_range(0, EMAX));
      endcase
      runOp(randOp(ea), randOp(eb), "R2 R3 R4 R5 R6 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule